// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block is the transmit half of a synchronous serial port that works as a slave. An external master drives the bit clock on an input pin. The block has no clock generator of its own. Software-side logic writes words into a one-deep holding register. Each word then moves into a shift register and leaves on the data pin, one bit for each falling edge of the external clock.

The holding register and the shift register together form a double buffer. If the shifter is idle, a written word goes straight into it, and the holding register stays empty. A word written while the shifter is busy waits in the holding register, and the holding-empty flag stays low. When the shifter finishes its word, the waiting word moves into it, and the holding-empty flag rises. When interrupts are enabled, that rise drives the interrupt output. An optional ninth bit goes out after the most significant data bit.

The port transmits only when all of these hold: synchronous mode is on, the port is enabled, the master-clock select is off, both receive enables are off, and transmit is enabled.

Top module: `sync_slave_tx`

## Requirements
- R1: After a synchronous reset, `hold_empty` and `shift_empty` both read 1 and both buffers hold no word.
- R2: The port is active only when `sync_mode`=1, `port_en`=1, `tx_en`=1, `clk_master_sel`=0, `rx_cont_en`=0 and `rx_single_en`=0. `sdo_oe` is 1 exactly when the port is active.
- R3: A write made while the port is active and the shifter is idle loads the shifter directly. `shift_empty` drops to 0, `hold_empty` stays 1, and `sdo` presents data bit 0.
- R4: Bits leave least significant first. `sdo` advances by one bit on each falling edge of `ext_sclk`, after a two-flop synchronizer, within 4 system clocks of that edge.
- R5: When `nine_bit_en`=1 at write time, the value of `wr_ninth` sampled with that write is sent as one extra bit after the most significant data bit. When `nine_bit_en`=0, no extra bit is sent.
- R6: A write made while the shifter is busy and the holding register is empty is stored in the holding register, and `hold_empty` reads 0.
- R7: On the falling edge that ends the current word, a waiting word moves into the shifter. `hold_empty` rises to 1, `shift_empty` stays 0, and `sdo` presents the new word's bit 0.
- R8: A write made while the holding register is full is dropped. The waiting word is not changed.
- R9: `irq` equals `irq_en` AND `hold_empty` AND port active.
- R10: After the falling edge that ends the last word, with nothing waiting, `shift_empty` returns to 1 and `sdo` idles at 1.
- R11: While the port is inactive, writes are ignored and both buffers are flushed. After the port is re-enabled, `hold_empty` and `shift_empty` read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_master_sel | input | 1 | Clock-source select (must be 0 for slave operation) |
| rx_cont_en | input | 1 | Continuous-receive enable (must be 0) |
| rx_single_en | input | 1 | Single-receive enable (must be 0) |
| tx_en | input | 1 | Transmit enable |
| nine_bit_en | input | 1 | Ninth-bit mode enable, sampled with each write |
| irq_en | input | 1 | Transmit interrupt enable |
| wr_valid | input | 1 | One-cycle write strobe |
| wr_data | input | DATA_W | Data word to send |
| wr_ninth | input | 1 | Ninth bit for the written word |
| ext_sclk | input | 1 | Bit clock from the external master |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the data pin |
| hold_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Transmit interrupt |

## Verification
The bench builds the block with `DATA_W`=4. At that width it can send every data value with both ninth-bit values, in both 8+1-style and plain modes, and check each serial bit position at the pin. The narrow word also keeps each frame short, so the double-buffer handoff, the dropped write while the holding register is full, and the flush after each kind of disable can be checked several times within the cycle budget.

// File: rtl/sts_pkg.sv
package sts_pkg;

    // Which path feeds the shifter in a given cycle
    typedef enum logic [1:0] {
        XFER_NONE      = 2'd0,
        XFER_DIRECT    = 2'd1,
        XFER_FROM_HOLD = 2'd2
    } xfer_e;

    // Number of serial bits in one frame
    function automatic int unsigned frame_bits(input int unsigned data_w,
                                               input logic        nine);
        return data_w + (nine ? 1 : 0);
    endfunction

    // All control conditions required for slave transmit
    function automatic logic slave_tx_ok(input logic port_en,
                                         input logic sync_mode,
                                         input logic clk_master_sel,
                                         input logic rx_cont_en,
                                         input logic rx_single_en,
                                         input logic tx_en);
        return port_en & sync_mode & ~clk_master_sel &
               ~rx_cont_en & ~rx_single_en & tx_en;
    endfunction

endpackage

// File: rtl/sts_clk_sync.sv
module sts_clk_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    output logic fall_pulse
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= pin_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[SYNC_STAGES-1];
    end

    assign fall_pulse = prev_q & ~chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/sts_hold_buf.sv
module sts_hold_buf #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              load,
    input  logic              take,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              full
);
    logic [WORD_W-1:0] word_q;
    logic              full_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            full_q <= 1'b0;
        end else if (load) begin
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else if (load) word_q <= din;
    end

    assign dout = word_q;
    assign full = full_q;

endmodule

// File: rtl/sts_shifter.sv
module sts_shifter #(
    parameter int DATA_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [DATA_W:0] load_bits,
    input  logic          load_nine,
    input  logic          shift_tick,
    output logic          bit_out,
    output logic          busy,
    output logic          last_tick
);
    import sts_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LEN_PLAIN = CNT_W'(frame_bits(DATA_W, 1'b0));
    localparam logic [CNT_W-1:0] LEN_NINE  = CNT_W'(frame_bits(DATA_W, 1'b1));

    logic [DATA_W:0]  sreg_q;
    logic [CNT_W-1:0] left_q;

    assign busy      = (left_q != '0);
    assign last_tick = shift_tick && (left_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sreg_q <= '0;
            left_q <= '0;
        end else if (load) begin
            sreg_q <= load_bits;
            left_q <= load_nine ? LEN_NINE : LEN_PLAIN;
        end else if (shift_tick && busy) begin
            sreg_q <= {1'b0, sreg_q[DATA_W:1]};
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign bit_out = sreg_q[0];

endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_master_sel,
    input  logic              rx_cont_en,
    input  logic              rx_single_en,
    input  logic              tx_en,
    input  logic              nine_bit_en,
    input  logic              irq_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ninth,
    input  logic              ext_sclk,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              hold_empty,
    output logic              shift_empty,
    output logic              irq
);
    import sts_pkg::*;

    localparam int HOLD_W = DATA_W + 2;

    typedef struct packed {
        logic              nine;
        logic              ninth;
        logic [DATA_W-1:0] data;
    } word_t;

    logic  active;
    logic  fall_pulse;
    logic  hold_full;
    logic  sh_busy;
    logic  sh_bit;
    logic  sh_last;
    logic  sh_free;
    logic  hold_load;
    logic  hold_take;
    logic  sh_load;
    xfer_e xfer;
    word_t wr_word;
    word_t held_word;
    word_t load_word;
    logic [HOLD_W-1:0] held_raw;

    assign active = slave_tx_ok(port_en, sync_mode, clk_master_sel,
                                rx_cont_en, rx_single_en, tx_en);

    sts_clk_sync #(.SYNC_STAGES(SYNC_STAGES)) clk_sync_i (
        .clk        (clk),
        .rst        (rst),
        .pin_in     (ext_sclk),
        .fall_pulse (fall_pulse)
    );

    always_comb begin
        wr_word.nine  = nine_bit_en;
        wr_word.ninth = nine_bit_en & wr_ninth;
        wr_word.data  = wr_data;
    end

    assign sh_free = ~sh_busy | sh_last;

    always_comb begin
        xfer      = XFER_NONE;
        hold_load = 1'b0;
        if (active) begin
            if (hold_full) begin
                if (sh_free) xfer = XFER_FROM_HOLD;
            end else if (wr_valid) begin
                if (sh_free) xfer = XFER_DIRECT;
                else         hold_load = 1'b1;
            end
        end
    end

    assign hold_take = (xfer == XFER_FROM_HOLD);
    assign sh_load   = (xfer != XFER_NONE);
    assign held_word = word_t'(held_raw);
    assign load_word = hold_take ? held_word : wr_word;

    sts_hold_buf #(.WORD_W(HOLD_W)) hold_i (
        .clk  (clk),
        .rst  (rst),
        .clr  (~active),
        .load (hold_load),
        .take (hold_take),
        .din  (wr_word),
        .dout (held_raw),
        .full (hold_full)
    );

    sts_shifter #(.DATA_W(DATA_W)) shift_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (~active),
        .load       (sh_load),
        .load_bits  ({load_word.ninth, load_word.data}),
        .load_nine  (load_word.nine),
        .shift_tick (fall_pulse & active),
        .bit_out    (sh_bit),
        .busy       (sh_busy),
        .last_tick  (sh_last)
    );

    assign sdo_oe      = active;
    assign sdo         = active & (sh_busy ? sh_bit : 1'b1);
    assign hold_empty  = ~hold_full;
    assign shift_empty = ~sh_busy;
    assign irq         = irq_en & ~hold_full & active;

endmodule

// File: rtl/sync_slave_tx_chk.sv
module sync_slave_tx_chk (
    input logic clk,
    input logic rst,
    input logic port_en,
    input logic sync_mode,
    input logic clk_master_sel,
    input logic rx_cont_en,
    input logic rx_single_en,
    input logic tx_en,
    input logic sdo,
    input logic sdo_oe,
    input logic hold_empty,
    input logic shift_empty,
    input logic irq
);
    logic act;
    assign act = port_en & sync_mode & ~clk_master_sel &
                 ~rx_cont_en & ~rx_single_en & tx_en;

    // R1: both buffers empty right after reset
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> (hold_empty && shift_empty));

    // R6: a waiting word implies the shifter is busy
    a_r6_hold_needs_busy: assert property (@(posedge clk) disable iff (rst)
        !hold_empty |-> !shift_empty);

    // R7: holding register empties by handing its word to the shifter
    a_r7_handoff: assert property (@(posedge clk) disable iff (rst)
        ($rose(hold_empty) && $past(act)) |-> !shift_empty);

    // R9: interrupt only while the holding register is empty
    a_r9_irq_empty: assert property (@(posedge clk) disable iff (rst)
        irq |-> hold_empty);

    // R10: idle line is high while driven
    a_r10_idle_high: assert property (@(posedge clk) disable iff (rst)
        (shift_empty && sdo_oe) |-> sdo);

    // R11: disable flushes both buffers
    a_r11_flush: assert property (@(posedge clk) disable iff (rst)
        !act |=> (hold_empty && shift_empty));

endmodule

bind sync_slave_tx sync_slave_tx_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .port_en        (port_en),
    .sync_mode      (sync_mode),
    .clk_master_sel (clk_master_sel),
    .rx_cont_en     (rx_cont_en),
    .rx_single_en   (rx_single_en),
    .tx_en          (tx_en),
    .sdo            (sdo),
    .sdo_oe         (sdo_oe),
    .hold_empty     (hold_empty),
    .shift_empty    (shift_empty),
    .irq            (irq)
);

// File: tb/sync_slave_tx_tb.sv
module sync_slave_tx_tb_top;
    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic port_en = 1'b1, sync_mode = 1'b1, clk_master_sel = 1'b0;
    logic rx_cont_en = 1'b0, rx_single_en = 1'b0, tx_en = 1'b1;
    logic nine_bit_en = 1'b0, irq_en = 1'b0;
    logic wr_valid = 1'b0, wr_ninth = 1'b0, ext_sclk = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic sdo, sdo_oe, hold_empty, shift_empty, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sync_slave_tx #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .port_en(port_en), .sync_mode(sync_mode),
        .clk_master_sel(clk_master_sel), .rx_cont_en(rx_cont_en),
        .rx_single_en(rx_single_en), .tx_en(tx_en), .nine_bit_en(nine_bit_en),
        .irq_en(irq_en), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ninth(wr_ninth), .ext_sclk(ext_sclk), .sdo(sdo), .sdo_oe(sdo_oe),
        .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [DW-1:0] d, input logic n);
        wr_data  = d;
        wr_ninth = n;
        wr_valid = 1'b1;
        cyc(1);
        wr_valid = 1'b0;
    endtask

    task automatic sclk_pulse();
        ext_sclk = 1'b1;
        cyc(4);
        ext_sclk = 1'b0;
        cyc(5);
    endtask

    // shift one frame out, checking each bit before its falling edge
    task automatic shift_word(input logic [DW-1:0] d, input logic n, input logic nine);
        int len;
        len = DW + (nine ? 1 : 0);
        for (int i = 0; i < len; i++) begin
            if (i < DW) chk("R4 data bit", sdo, d[i]);
            else        chk("R5 ninth bit", sdo, n);
            sclk_pulse();
        end
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(2);
        // R1 reset state
        chk("R1 hold_empty", hold_empty, 1);
        chk("R1 shift_empty", shift_empty, 1);
        chk("R2 sdo_oe active", sdo_oe, 1);
        chk("R10 idle sdo", sdo, 1);

        // Sweep: all data values, both ninth values, both modes
        for (int nine = 0; nine < 2; nine++) begin
            for (int n = 0; n < 2; n++) begin
                for (int d = 0; d < (1 << DW); d++) begin
                    nine_bit_en = nine[0];
                    write(DW'(d), n[0]);
                    cyc(2);
                    chk("R3 shift_empty low", shift_empty, 0);
                    chk("R3 hold_empty stays", hold_empty, 1);
                    shift_word(DW'(d), n[0], nine[0]);
                    chk("R10 shift_empty back", shift_empty, 1);
                    chk("R10 idle sdo", sdo, 1);
                end
            end
        end

        // Double buffering with interrupt
        nine_bit_en = 1'b0;
        irq_en = 1'b1;
        cyc(1);
        chk("R9 irq when empty", irq, 1);
        write(4'h5, 1'b0);
        write(4'hA, 1'b0);
        cyc(1);
        chk("R6 hold_empty low", hold_empty, 0);
        chk("R6 shift busy", shift_empty, 0);
        chk("R9 irq low while full", irq, 0);
        write(4'h3, 1'b0);   // dropped
        cyc(1);
        chk("R8 still one waiting", hold_empty, 0);
        for (int i = 0; i < DW - 1; i++) begin
            chk("R4 first word bit", sdo, (4'h5 >> i) & 1);
            sclk_pulse();
            chk("R6 waiting during shift", hold_empty, 0);
        end
        chk("R4 first word msb", sdo, 0);
        sclk_pulse();
        chk("R7 hold_empty rises", hold_empty, 1);
        chk("R7 shifter reloaded", shift_empty, 0);
        chk("R9 irq raised", irq, 1);
        shift_word(4'hA, 1'b0, 1'b0);
        chk("R8 dropped word absent", shift_empty, 1);

        // Nine-bit handoff, ninth value tied to each write
        nine_bit_en = 1'b1;
        write(4'h9, 1'b1);
        write(4'h6, 1'b0);
        cyc(1);
        shift_word(4'h9, 1'b1, 1'b1);
        chk("R7 hold_empty after 9-bit frame", hold_empty, 1);
        shift_word(4'h6, 1'b0, 1'b1);
        chk("R10 empty after pair", shift_empty, 1);
        nine_bit_en = 1'b0;

        // Each disabling condition: writes ignored, buffers flushed
        for (int k = 0; k < 6; k++) begin
            write(4'hC, 1'b0);
            write(4'h1, 1'b0);
            case (k)
                0: port_en = 1'b0;
                1: sync_mode = 1'b0;
                2: clk_master_sel = 1'b1;
                3: rx_cont_en = 1'b1;
                4: rx_single_en = 1'b1;
                default: tx_en = 1'b0;
            endcase
            cyc(1);
            chk("R2 sdo_oe off", sdo_oe, 0);
            chk("R9 irq off when inactive", irq, 0);
            write(4'h7, 1'b0);
            sclk_pulse();
            port_en = 1'b1; sync_mode = 1'b1; clk_master_sel = 1'b0;
            rx_cont_en = 1'b0; rx_single_en = 1'b0; tx_en = 1'b1;
            cyc(1);
            chk("R11 hold flushed", hold_empty, 1);
            chk("R11 shift flushed", shift_empty, 1);
            chk("R2 sdo_oe back", sdo_oe, 1);
        end

        // Reset mid-frame
        write(4'hE, 1'b0);
        write(4'h2, 1'b0);
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        cyc(1);
        chk("R1 hold after reset", hold_empty, 1);
        chk("R1 shift after reset", shift_empty, 1);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule